// File: doc/BRIEF.md
# Least-Reliable Position Collector

This block watches a serial stream of soft symbols, one per clock, and keeps the few positions whose reliability is weakest. Each symbol is a sign-magnitude value: the top bit is the sign and the remaining bits are the reliability magnitude. The block passes the hard decision straight through. It also keeps a short chain of register stages, sorted by ascending magnitude.

Each stage holds three things: a magnitude, the integer position of that symbol in the codeword, and the Galois-field locator of that position. The locator is the primitive element raised to the position index. A single constant multiplier builds the locators from one running register. When the last symbol of a codeword has been taken, a one-cycle done pulse marks that the stored locator and position sets are final. A downstream magnitude solver can then read them without a search over every root of the field.

The block runs alongside a syndrome calculator over the same input cycles. A start pulse clears it before each codeword.

Top module: `lrb_eval`

## Requirements
- R1: The cycle after start_i (or after reset), every stage magnitude equals the largest code (all ones, 63 by default), every stage position and locator is 0, and the next accepted symbol gets position 0.
- R2: Stage magnitudes stay in non-decreasing order from stage 0 to stage DELTA-1 at all times.
- R3: An accepted symbol with magnitude m is placed behind every stored entry whose magnitude is at most m and ahead of every larger one. Later entries move down one stage, and the entry in the last stage is dropped. Equal magnitudes therefore keep the earlier position ahead.
- R4: An accepted symbol whose magnitude is the largest code never enters any stage.
- R5: The locator stored with position j is alpha^j in GF(2^8) with primitive polynomial 0x11D, where alpha = 0x02; position 0 carries locator 0x01.
- R6: Each accepted symbol, kept or not, advances the position counter by exactly one.
- R7: done_o is high for exactly the one cycle after a symbol accepted with last_i high.
- R8: hard_o is the inverse of soft_i bit 6, the sign bit. Bits 5:0 are the magnitude.
- R9: A cycle with valid_i low changes no stage contents.
- R10: A symbol presented in the same cycle as start_i is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start-of-codeword clear pulse |
| valid_i | input | 1 | soft_i carries a symbol this cycle |
| last_i | input | 1 | Symbol is the last of the codeword |
| soft_i | input | 7 | Sign-magnitude soft symbol |
| hard_o | output | 1 | Hard decision of soft_i |
| done_o | output | 1 | Candidate sets are final |
| mag_o | output | 24 | Stage magnitudes, stage k at [6k+5:6k] |
| loc_o | output | 32 | Stage locators, stage k at [8k+7:8k] |
| pos_o | output | 32 | Stage positions, stage k at [8k+7:8k] |

## Verification
The bench uses the default parameters: GF(2^8), four stages and a 7-bit soft symbol. With these values a full 255-symbol codeword fits within the run. That codeword drives the locator register through every power of alpha, including the wrap from alpha^254. Four stages are enough to exercise the edge cases: insertion at the head, insertion in the middle, insertion at the tail, ties between equal magnitudes, and dropping the last entry. Because the magnitude is only six bits wide, the never-kept maximum code is easy to reach on purpose.

// File: rtl/lrb_pkg.sv
package lrb_pkg;
    // what a stage does at the next edge
    typedef enum logic [1:0] {
        SEL_HOLD = 2'd0,
        SEL_PREV = 2'd1,
        SEL_IN   = 2'd2,
        SEL_CLR  = 2'd3
    } stage_sel_e;
endpackage

// File: rtl/lrb_locgen.sv
module lrb_locgen #(
    parameter int          M    = 8,
    parameter logic [M:0]  POLY = 9'h11D,
    parameter int          PW   = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          step,
    output logic [M-1:0]  loc,
    output logic [PW-1:0] pos
);
    typedef struct packed {
        logic [M-1:0]  loc;
        logic [PW-1:0] pos;
    } gen_t;

    localparam logic [M-1:0] ONE = M'(1);

    gen_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr) begin
            st_d.loc = ONE;
            st_d.pos = '0;
        end else if (step) begin
            // constant multiply by alpha: shift, reduce on overflow
            st_d.loc = {st_q.loc[M-2:0], 1'b0} ^ (st_q.loc[M-1] ? POLY[M-1:0] : '0);
            st_d.pos = st_q.pos + PW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.loc <= ONE;
            st_q.pos <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign loc = st_q.loc;
    assign pos = st_q.pos;
endmodule

// File: rtl/lrb_stage.sv
module lrb_stage
    import lrb_pkg::*;
#(
    parameter int MW    = 6,
    parameter int M     = 8,
    parameter int PW    = 8,
    parameter bit FIRST = 1'b0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          take,
    input  logic [MW-1:0] prev_mag,
    input  logic [M-1:0]  prev_loc,
    input  logic [PW-1:0] prev_pos,
    input  logic [MW-1:0] in_mag,
    input  logic [M-1:0]  in_loc,
    input  logic [PW-1:0] in_pos,
    output logic [MW-1:0] mag,
    output logic [M-1:0]  loc,
    output logic [PW-1:0] pos
);
    typedef struct packed {
        logic [MW-1:0] mag;
        logic [M-1:0]  loc;
        logic [PW-1:0] pos;
    } ent_t;

    localparam logic [MW-1:0] MAG_MAX = '1;

    ent_t       ent_d, ent_q;
    stage_sel_e sel;
    logic       beats_prev, beats_self;

    always_comb begin
        beats_prev = FIRST ? 1'b0 : (in_mag < prev_mag);
        beats_self = in_mag < ent_q.mag;
        if (clr)                    sel = SEL_CLR;
        else if (!take)             sel = SEL_HOLD;
        else if (beats_prev)        sel = SEL_PREV;
        else if (beats_self)        sel = SEL_IN;
        else                        sel = SEL_HOLD;

        ent_d = ent_q;
        unique case (sel)
            SEL_CLR:  ent_d = '{mag: MAG_MAX, loc: '0, pos: '0};
            SEL_PREV: ent_d = '{mag: prev_mag, loc: prev_loc, pos: prev_pos};
            SEL_IN:   ent_d = '{mag: in_mag, loc: in_loc, pos: in_pos};
            default:  ent_d = ent_q;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ent_q <= '{mag: MAG_MAX, loc: '0, pos: '0};
        else        ent_q <= ent_d;
    end

    assign mag = ent_q.mag;
    assign loc = ent_q.loc;
    assign pos = ent_q.pos;
endmodule

// File: rtl/lrb_eval.sv
module lrb_eval #(
    parameter int         M      = 8,
    parameter logic [M:0] POLY   = 9'h11D,
    parameter int         NMAX   = 255,
    parameter int         DELTA  = 4,
    parameter int         SOFT_W = 7,
    localparam int        MW     = SOFT_W - 1,
    localparam int        PW     = $clog2(NMAX + 1)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start_i,
    input  logic                  valid_i,
    input  logic                  last_i,
    input  logic [SOFT_W-1:0]     soft_i,
    output logic                  hard_o,
    output logic                  done_o,
    output logic [DELTA*MW-1:0]   mag_o,
    output logic [DELTA*M-1:0]    loc_o,
    output logic [DELTA*PW-1:0]   pos_o
);
    logic          accept;
    logic [MW-1:0] in_mag;
    logic [M-1:0]  cur_loc;
    logic [PW-1:0] cur_pos;

    logic [MW-1:0] smag [DELTA];
    logic [M-1:0]  sloc [DELTA];
    logic [PW-1:0] spos [DELTA];

    logic done_d, done_q;

    assign accept = valid_i && !start_i;
    assign in_mag = soft_i[MW-1:0];
    assign hard_o = ~soft_i[SOFT_W-1];

    lrb_locgen #(.M(M), .POLY(POLY), .PW(PW)) u_locgen (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (start_i),
        .step  (accept),
        .loc   (cur_loc),
        .pos   (cur_pos)
    );

    for (genvar k = 0; k < DELTA; k++) begin : g_stage
        localparam int PK = (k == 0) ? 0 : k - 1;
        lrb_stage #(.MW(MW), .M(M), .PW(PW), .FIRST(k == 0)) u_stage (
            .clk      (clk),
            .rst_n    (rst_n),
            .clr      (start_i),
            .take     (accept),
            .prev_mag (smag[PK]),
            .prev_loc (sloc[PK]),
            .prev_pos (spos[PK]),
            .in_mag   (in_mag),
            .in_loc   (cur_loc),
            .in_pos   (cur_pos),
            .mag      (smag[k]),
            .loc      (sloc[k]),
            .pos      (spos[k])
        );
        assign mag_o[k*MW +: MW] = smag[k];
        assign loc_o[k*M  +: M ] = sloc[k];
        assign pos_o[k*PW +: PW] = spos[k];
    end

    always_comb begin
        done_d = accept && last_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) done_q <= 1'b0;
        else        done_q <= done_d;
    end

    assign done_o = done_q;
endmodule

// File: rtl/lrb_eval_chk.sv
module lrb_eval_chk #(
    parameter int M     = 8,
    parameter int DELTA = 4,
    parameter int MW    = 6,
    parameter int PW    = 8
) (
    input logic                clk,
    input logic                rst_n,
    input logic                start_i,
    input logic                valid_i,
    input logic                last_i,
    input logic [MW:0]         soft_i,
    input logic                done_o,
    input logic [DELTA*MW-1:0] mag_o,
    input logic [DELTA*M-1:0]  loc_o,
    input logic [DELTA*PW-1:0] pos_o
);
    localparam logic [DELTA*MW-1:0] ALL_MAX = '1;
    localparam logic [MW-1:0]       MAG_MAX = '1;

    // R1
    clear_to_max_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> (mag_o == ALL_MAX));

    for (genvar k = 1; k < DELTA; k++) begin : g_ord
        // R2
        sorted_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
            mag_o[(k-1)*MW +: MW] <= mag_o[k*MW +: MW]);
    end

    // R4
    max_never_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && !start_i && soft_i[MW-1:0] == MAG_MAX)
            |=> ($stable(mag_o) && $stable(loc_o) && $stable(pos_o)));

    // R7
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> $past(valid_i && last_i && !start_i));

    // R7
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o || $past(valid_i && last_i && !start_i));

    // R9
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!valid_i && !start_i) |=> ($stable(mag_o) && $stable(loc_o) && $stable(pos_o)));
endmodule

bind lrb_eval lrb_eval_chk #(.M(M), .DELTA(DELTA), .MW(MW), .PW(PW)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (start_i),
    .valid_i (valid_i),
    .last_i  (last_i),
    .soft_i  (soft_i),
    .done_o  (done_o),
    .mag_o   (mag_o),
    .loc_o   (loc_o),
    .pos_o   (pos_o)
);

// File: tb/lrb_eval_tb.sv
module lrb_eval_tb;
    localparam int D = 4;
    localparam int MW = 6;
    localparam int M = 8;
    localparam int PW = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_i = 1'b0, valid_i = 1'b0, last_i = 1'b0;
    logic [6:0] soft_i = '0;
    logic hard_o, done_o;
    logic [D*MW-1:0] mag_o;
    logic [D*M-1:0]  loc_o;
    logic [D*PW-1:0] pos_o;

    int n_chk = 0, n_fail = 0;
    bit finished = 1'b0;

    // reference candidate list
    int rm [D];
    int rl [D];
    int rp [D];
    int rpos;

    always #2 clk = ~clk;

    lrb_eval u_dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .valid_i(valid_i),
        .last_i(last_i), .soft_i(soft_i), .hard_o(hard_o), .done_o(done_o),
        .mag_o(mag_o), .loc_o(loc_o), .pos_o(pos_o)
    );

    localparam logic [6:0] VEC [8] = '{7'h14, 7'h45, 7'h28, 7'h05, 7'h42, 7'h3F, 7'h5E, 7'h0A};
    localparam bit         HEXP [8] = '{1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1};
    localparam int EXP_MAG [4] = '{2, 5, 5, 10};
    localparam int EXP_POS [4] = '{4, 1, 3, 7};
    localparam int EXP_LOC [4] = '{8'h10, 8'h02, 8'h08, 8'h80};

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int apow(input int n);
        int v = 1;
        for (int i = 0; i < n; i++) begin
            v = v << 1;
            if (v & 256) v = v ^ 9'h11D;
        end
        return v;
    endfunction

    function automatic void model_clear();
        for (int k = 0; k < D; k++) begin
            rm[k] = 63; rl[k] = 0; rp[k] = 0;
        end
        rpos = 0;
    endfunction

    function automatic void model_put(input int m);
        int at = D;
        for (int k = D - 1; k >= 0; k--) if (m < rm[k]) at = k;
        if (at < D) begin
            for (int k = D - 1; k > at; k--) begin
                rm[k] = rm[k-1]; rl[k] = rl[k-1]; rp[k] = rp[k-1];
            end
            rm[at] = m; rl[at] = apow(rpos); rp[at] = rpos;
        end
        rpos++;
    endfunction

    task automatic cmp_all(input string req);
        for (int k = 0; k < D; k++) begin
            chk(int'(mag_o[k*MW +: MW]) == rm[k], req, int'(mag_o[k*MW +: MW]), rm[k]);
            chk(int'(loc_o[k*M +: M]) == rl[k], req, int'(loc_o[k*M +: M]), rl[k]);
            chk(int'(pos_o[k*PW +: PW]) == rp[k], req, int'(pos_o[k*PW +: PW]), rp[k]);
        end
    endtask

    task automatic do_start();
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        model_clear();
    endtask

    task automatic put(input logic [6:0] s, input bit last);
        valid_i = 1'b1; soft_i = s; last_i = last;
        @(negedge clk);
        valid_i = 1'b0; last_i = 1'b0;
        model_put(int'(s[5:0]));
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        #400000;
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        finish_run();
    end

    initial begin
        logic [7:0] lf;
        model_clear();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        cmp_all("R1");
        chk(done_o == 1'b0, "R7", int'(done_o), 0);

        // table walk: R3 R5 R8 R7
        do_start();
        for (int i = 0; i < 8; i++) begin
            valid_i = 1'b1; soft_i = VEC[i]; last_i = (i == 7);
            #1;
            chk(hard_o == HEXP[i], "R8", int'(hard_o), int'(HEXP[i]));
            @(negedge clk);
            valid_i = 1'b0; last_i = 1'b0;
            model_put(int'(VEC[i][5:0]));
            chk(done_o == (i == 7), "R7", int'(done_o), int'(i == 7));
        end
        for (int k = 0; k < D; k++) begin
            chk(int'(mag_o[k*MW +: MW]) == EXP_MAG[k], "R3", int'(mag_o[k*MW +: MW]), EXP_MAG[k]);
            chk(int'(pos_o[k*PW +: PW]) == EXP_POS[k], "R3", int'(pos_o[k*PW +: PW]), EXP_POS[k]);
            chk(int'(loc_o[k*M +: M]) == EXP_LOC[k], "R5", int'(loc_o[k*M +: M]), EXP_LOC[k]);
        end
        @(negedge clk);
        chk(done_o == 1'b0, "R7", int'(done_o), 0);
        // R9 idle cycles hold
        repeat (5) @(negedge clk);
        cmp_all("R9");

        // R1 start clears
        do_start();
        cmp_all("R1");

        // R4 maximum magnitude never kept, R6 counter still advances
        put(7'h3F, 1'b0);
        put(7'h7F, 1'b0);
        cmp_all("R4");
        put(7'h01, 1'b0);
        chk(int'(pos_o[PW-1:0]) == 2, "R6", int'(pos_o[PW-1:0]), 2);
        chk(int'(loc_o[M-1:0]) == 4, "R5", int'(loc_o[M-1:0]), 4);

        // R10 symbol with start ignored
        start_i = 1'b1; valid_i = 1'b1; soft_i = 7'h00; last_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0; valid_i = 1'b0; last_i = 1'b0;
        model_clear();
        cmp_all("R10");
        chk(done_o == 1'b0, "R10", int'(done_o), 0);
        put(7'h03, 1'b0);
        chk(int'(pos_o[PW-1:0]) == 0, "R10", int'(pos_o[PW-1:0]), 0);

        // full 255-symbol codeword with ties: R3 R5 R6 R7
        do_start();
        lf = 8'hA5;
        for (int i = 0; i < 255; i++) begin
            logic [6:0] s;
            lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
            s = {lf[0], 1'b0, lf[7:3]} | 7'h08;
            if (i == 254) s = 7'h48;
            if (i == 200) s = 7'h09;
            put(s, i == 254);
        end
        chk(done_o == 1'b1, "R7", int'(done_o), 1);
        cmp_all("R3");
        for (int k = 0; k < D; k++)
            chk(int'(loc_o[k*M +: M]) == apow(int'(pos_o[k*PW +: PW])), "R5",
                int'(loc_o[k*M +: M]), apow(int'(pos_o[k*PW +: PW])));

        // tie order and tail drop: R3
        do_start();
        put(7'h07, 1'b0); put(7'h47, 1'b0); put(7'h07, 1'b0);
        put(7'h07, 1'b0); put(7'h07, 1'b0); put(7'h02, 1'b1);
        chk(int'(pos_o[PW +: PW]) == 0, "R3", int'(pos_o[PW +: PW]), 0);
        chk(int'(pos_o[3*PW +: PW]) == 2, "R3", int'(pos_o[3*PW +: PW]), 2);
        cmp_all("R3");

        finish_run();
    end
endmodule